// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns the digitized results of two supply comparators into a clean chip-level reset and an output gate. One flag says the supply is above the upper trip point (about 4.2 V). The other says it is below the lower trip point (about 4.0 V). The roughly 200 mV gap between the two trip points gives hysteresis. Reset is driven as soon as the supply drops below the lower point. Reset is released only after the supply has climbed past the upper point. An external active-low master-clear forces the same reset state.

Reset release does not unblock the outputs at once. A second, long settling timer holds the pulse-enable low for a set number of clock cycles after every release. The default is 3,580,000 cycles, which is about one second at 3.58 MHz. A supply dip during that interval re-enters reset, and the next release restarts the full interval. Both comparator flags and the master-clear release pass through two-flop synchronizers before they reach the three-state controller. The three states are reset, settling and run.

Top module: `supply_rst_seq`

## Requirements
- R1: While `mclr_n` is 0, `rst_n_out` and `pulse_en` are 0. This takes effect asynchronously, without waiting for a clock edge, from any state.
- R2: `mclr_n` is released synchronously. After `mclr_n` rises, with the supply already above the upper trip point, `rst_n_out` stays 0 for 4 rising edges and becomes 1 after the 5th.
- R3: `sup_below` = 1 puts the block into reset from any state. `rst_n_out` and `pulse_en` are 0 after the 3rd rising edge following the change and unchanged after the 2nd.
- R4: From reset, `sup_above` = 1 with `sup_below` = 0 releases reset. `rst_n_out` becomes 1 after the 3rd rising edge and is unchanged after the 2nd.
- R5: When both flags are 0 (supply between the trip points), the current state is kept. Reset stays asserted, settling continues, and run stays in run.
- R6: When both flags are 1, an illegal combination, `sup_below` wins and reset is asserted.
- R7: After each reset release, `pulse_en` stays 0 for exactly `SETTLE_CYCLES` clock cycles with `rst_n_out` = 1, and then becomes 1.
- R8: Reset reasserted during the settling interval, even by a one-cycle dip, restarts the count. The next release again waits the full `SETTLE_CYCLES` cycles.
- R9: `pulse_en` is 1 only in the run state, so `pulse_en` = 1 never occurs together with `rst_n_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mclr_n | input | 1 | External master-clear, active low, asynchronous assert |
| sup_above | input | 1 | Comparator flag: supply above upper trip point |
| sup_below | input | 1 | Comparator flag: supply below lower trip point |
| rst_n_out | output | 1 | Internal reset, active low |
| pulse_en | output | 1 | Output pulse enable, high only after settling |

## Verification
The bench brings the controller into each of its three states and then applies each of the four flag combinations. It then compares the outputs two and three edges later with the outcome it predicts for that state and combination. This separates the priority of the below flag, the hold behaviour in the hysteresis gap, and the release path, and it also pins the synchronizer latency. The settling length is counted cycle by cycle after a clean power-up and again after a one-cycle dip in mid-count, which tells a restarted count from a resumed one. Master-clear is dropped between clock edges, both at start-up and in the run state, to show that it acts without a clock.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } sup_state_e;

  // Next state from synchronized flags; below has priority over above.
  function automatic sup_state_e sup_next(input sup_state_e cur,
                                          input logic below,
                                          input logic above,
                                          input logic done);
    sup_state_e nxt;
    nxt = cur;
    if (below) begin
      nxt = ST_RESET;
    end else begin
      case (cur)
        ST_RESET:  nxt = above ? ST_SETTLE : ST_RESET;
        ST_SETTLE: nxt = done ? ST_RUN : ST_SETTLE;
        ST_RUN:    nxt = ST_RUN;
        default:   nxt = ST_RESET;
      endcase
    end
    return nxt;
  endfunction

  // Counter width needed for a terminal value of limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/sup_sync_chain.sv
module sup_sync_chain #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[0] <= RST_VAL;
          else         stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[i] <= RST_VAL;
          else         stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sup_settle_timer.sv
module sup_settle_timer
  import supply_rst_pkg::*;
#(
  parameter int unsigned LIMIT = 3580000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST) else $error("count past limit"); // R7

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)) else $error("count not restarted"); // R8

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import supply_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_s,
  input  logic       above_s,
  input  logic       done,
  output sup_state_e state_o,
  output logic       settle_o,
  output logic       rst_n_o,
  output logic       pulse_en_o
);

  sup_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= sup_next(state, below_s, above_s, done);
  end

  assign state_o    = state;
  assign settle_o   = (state == ST_SETTLE);
  assign rst_n_o    = (state != ST_RESET);
  assign pulse_en_o = (state == ST_RUN);

  AST_BELOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    below_s |=> (state == ST_RESET)) else $error("below ignored"); // R3

  AST_RISE_TO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET && above_s && !below_s) |=> (state == ST_SETTLE))
    else $error("no release"); // R4

  AST_GAP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_s && !above_s && state != ST_SETTLE) |=> $stable(state))
    else $error("gap moved state"); // R5

  AST_BOTH_HOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (below_s && above_s) |=> !rst_n_o) else $error("illegal pair released"); // R6

  AST_RUN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_en_o) |-> $past(done)) else $error("early enable"); // R7

  AST_PEN_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en_o |-> rst_n_o) else $error("enable during reset"); // R9

endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq
  import supply_rst_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 3580000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic mclr_n,
  input  logic sup_above,
  input  logic sup_below,
  output logic rst_n_out,
  output logic pulse_en
);

  // Flag vector layout: bit 1 = above, bit 0 = below.
  localparam logic [1:0] FLAG_SAFE = 2'b01;

  logic       rst_sync_n;
  logic [1:0] flags_s;
  logic       below_s;
  logic       above_s;
  logic       settle;
  logic       done;
  sup_state_e state;

  // Master-clear: asynchronous assert, synchronous release.
  sup_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mclr_sync (
    .clk    (clk),
    .arst_n (mclr_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  // Comparator flags, held at "below" while in master-clear.
  sup_sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_SAFE)) u_flag_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      ({sup_above, sup_below}),
    .q      (flags_s)
  );

  assign below_s = flags_s[0];
  assign above_s = flags_s[1];

  sup_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (settle),
    .done  (done)
  );

  sup_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .below_s    (below_s),
    .above_s    (above_s),
    .done       (done),
    .state_o    (state),
    .settle_o   (settle),
    .rst_n_o    (rst_n_out),
    .pulse_en_o (pulse_en)
  );

  AST_SETTLE_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    settle |-> (rst_n_out && !pulse_en && state == ST_SETTLE))
    else $error("settle outputs wrong"); // R7

  AST_DONE_ONLY_SETTLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> settle) else $error("done outside settle"); // R8

endmodule

// File: tb/sim_supply_rst_seq.sv
module sim_supply_rst_seq;

  localparam int unsigned LIMIT = 12;
  // Bench-side state codes: 0 reset, 1 settling, 2 run.
  localparam int S_RST = 0, S_SET = 1, S_RUN = 2;

  logic clk = 1'b0;
  logic mclr_n = 1'b1;
  logic sup_above = 1'b0;
  logic sup_below = 1'b1;
  logic rst_n_out, pulse_en;

  int checks = 0;
  int errors = 0;
  int both_bad = 0;

  always #10 clk = ~clk;

  supply_rst_seq #(.SETTLE_CYCLES(LIMIT)) u0 (
    .clk       (clk),
    .mclr_n    (mclr_n),
    .sup_above (sup_above),
    .sup_below (sup_below),
    .rst_n_out (rst_n_out),
    .pulse_en  (pulse_en)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rst_n_out,pulse_en} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] outs_of(input int s);
    return (s == S_RST) ? 2'b00 : (s == S_SET) ? 2'b10 : 2'b11;
  endfunction

  // Count samples with reset released and enable low, until enable rises.
  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      if (rst_n_out && !pulse_en) n++;
      else break;
      @(negedge clk);
    end
  endtask

  task automatic go_state(input int s);
    sup_below = 1'b1; sup_above = 1'b0;
    edges(4);
    if (s != S_RST) begin
      sup_below = 1'b0; sup_above = 1'b1;
      edges(3);
      if (s == S_RUN) edges(LIMIT);
    end
  endtask

  // Enable must never be high during reset (R9).
  always @(negedge clk) if (pulse_en && !rst_n_out) both_bad++;

  task automatic finish_run;
    chk_int("R9 enable seen during reset", both_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    #3 mclr_n = 1'b0;
    #1 chk("R1 async clear at start", {rst_n_out, pulse_en}, 2'b00);
    sup_below = 1'b0; sup_above = 1'b1;
    edges(5);
    chk("R1 held under master-clear", {rst_n_out, pulse_en}, 2'b00);

    mclr_n = 1'b1;
    edges(4);
    chk("R2 still held after 4 edges", {rst_n_out, pulse_en}, 2'b00);
    edges(1);
    chk("R2 released after 5 edges", {rst_n_out, pulse_en}, 2'b10);
    measure(n);
    chk_int("R7 settle length", n, LIMIT);
    chk("R7 enable after settling", {rst_n_out, pulse_en}, 2'b11);

    // Async master-clear in run, mid-cycle.
    #3 mclr_n = 1'b0;
    #1 chk("R1 async clear from run", {rst_n_out, pulse_en}, 2'b00);
    edges(2);
    mclr_n = 1'b1;
    edges(6);

    // Sweep: every state against every flag pair.
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic b, a;
        int ex;
        string req;
        b = c[0]; a = c[1];
        go_state(s);
        ex = b ? S_RST : ((a && s == S_RST) ? S_SET : s);
        req = (b && a) ? "R6 both flags" : b ? "R3 below" :
              a ? "R4 above" : "R5 gap hold";
        sup_below = b; sup_above = a;
        edges(2);
        chk({req, " before latency"}, {rst_n_out, pulse_en}, outs_of(s));
        edges(1);
        chk({req, " after latency"}, {rst_n_out, pulse_en}, outs_of(ex));
      end
    end

    // One-cycle dip during settling restarts the count.
    go_state(S_SET);
    edges(5);
    sup_below = 1'b1; sup_above = 1'b0;
    edges(1);
    sup_below = 1'b0; sup_above = 1'b1;
    edges(2);
    chk("R3 dip re-enters reset", {rst_n_out, pulse_en}, 2'b00);
    edges(1);
    chk("R8 release after dip", {rst_n_out, pulse_en}, 2'b10);
    measure(n);
    chk_int("R8 full restart of settle", n, LIMIT);

    // Gap during settling keeps counting.
    go_state(S_SET);
    sup_above = 1'b0;
    measure(n);
    chk_int("R5 gap continues settle", n, LIMIT);
    chk("R5 run reached in gap", {rst_n_out, pulse_en}, 2'b11);

    finish_run();
  end

endmodule